// File: doc/BRIEF.md
# Dual-Mode 8-Bit Host Register Port

This block is the slave side of an 8-bit microcontroller bus. It lets a host reach a small internal register file. The register file holds an interrupt status byte, an interrupt enable byte, the access stretch length, a constant identity byte and a row of scratch bytes. A 3-bit mode code chooses between two bus modes, or leaves the port inactive. In separate mode the host drives the register address on its own address bus, and the data bus carries only data. In shared mode the host first puts the address on the data bus and marks it with an address-latch strobe. The port captures that address when the strobe falls, and later accesses use it.

An access begins when chip select and one of the two strobes are low, all active-low and sampled on the core clock. The port holds its active-low wait output low for a programmable number of core clocks, then releases it. Writes take effect at that release, and read data is driven from that point until the strobes are released. Core events set status bits. The active-low interrupt output is low while any status bit has its enable bit set. The host clears a status bit by writing 1 to it.

The cycle controller is a state machine with three states. ST_IDLE waits for a request. It goes to ST_STRETCH when the stretch length is non-zero, or straight to ST_READY (committing) when it is zero. ST_STRETCH counts down. It goes to ST_READY (committing) when the count is spent, or back to ST_IDLE (abort) if the host drops its strobes or the mode becomes inactive. ST_READY goes back to ST_IDLE when the strobes are released.

Top module: `hostreg_port`

## Requirements
- R1: Mode code 3'b011 selects separate mode and 3'b001 selects shared mode. With any other code, no access starts, wait_n stays high, dat_oe stays low and no register changes.
- R2: In separate mode the register address is host_addr, sampled at the edge where the access starts. The address-latch strobe is ignored and leaves the shared-mode address unchanged.
- R3: In shared mode, at a clock edge where ale was 1 at the previous edge and is 0 now, the port captures dat_in as the address. All later shared-mode accesses use that address.
- R4: An access starts at an edge where cs_n is 0 and we_n or re_n is 0 (a write if we_n is 0). wait_n is then low for exactly the programmed stretch length in cycles. A length of 0 never drives it low.
- R5: A write stores dat_in as sampled at the edge where wait_n is released (the start edge for length 0). Each access stores exactly once, and a further access needs the strobes released first.
- R6: A read drives dat_oe high and dat_out with the register value from the cycle after the release edge until the edge after the strobes are released.
- R7: If cs_n or the active strobe goes high while wait_n is low, the access is abandoned: no write takes effect and dat_oe stays low.
- R8: Register map. 0x00 is interrupt status (write 1 to clear). 0x01 is interrupt enable. 0x02 is the stretch length (low WAIT_W bits, reset value WAIT_RST). 0x03 is a read-only identity byte (ID_VAL, default 0xA7). 0x10 to 0x10+NSCR-1 are scratch bytes (reset 0). Any other address reads 0x00, and writes to it are ignored.
- R9: A 1 on evt_in bit i sets status bit i at the next edge. A set wins over a clear written in the same cycle.
- R10: irq_n is low exactly while some status bit and its enable bit are both 1. This follows changes to either byte in the cycle after the edge that makes them.
- R11: After reset wait_n and irq_n are high, dat_oe is low, and status and enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 3 | Bus mode code |
| host_addr | input | 8 | Address bus (separate mode) |
| dat_in | input | 8 | Data bus into the port; carries the address phase in shared mode |
| dat_out | output | 8 | Read data toward the host |
| dat_oe | output | 1 | High while read data is driven |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Address-latch strobe (shared mode) |
| wait_n | output | 1 | Access stretch, active low |
| irq_n | output | 1 | Interrupt to host, active low |
| evt_in | input | 8 | Core event pulses that set status bits |

## Verification
If the request is sampled at edge k and the stretch length is L, wait_n is low in the L cycles after edge k. Read data and dat_oe appear after edge k+L, or after edge k when L is 0. Status and interrupt changes appear in the cycle after the edge that samples the event or the write. The bench drives on falling edges and samples on falling edges. It counts the low cycles of wait_n one falling edge at a time. A scoreboard monitor compares read data on the falling edge where dat_oe first appears high. Interrupt and status expectations are checked on the falling edge that follows the causing edge.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    localparam logic [2:0] MODE_SEP = 3'b011;
    localparam logic [2:0] MODE_SHR = 3'b001;

    localparam logic [7:0] A_STATUS = 8'h00;
    localparam logic [7:0] A_ENABLE = 8'h01;
    localparam logic [7:0] A_STRCH  = 8'h02;
    localparam logic [7:0] A_IDENT  = 8'h03;
    localparam logic [7:0] A_SCR    = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_READY   = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/hrp_addr_path.sv
module hrp_addr_path
    import hrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       ale,
    input  logic [7:0] host_addr,
    input  logic [7:0] dat_in,
    output logic       mode_ok,
    output logic [7:0] eff_addr,
    output logic [7:0] lat_addr
);
    logic is_sep;
    logic is_shr;
    logic ale_q;

    assign is_sep  = (mode_sel == MODE_SEP);
    assign is_shr  = (mode_sel == MODE_SHR);
    assign mode_ok = is_sep | is_shr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q    <= 1'b0;
            lat_addr <= '0;
        end else begin
            ale_q <= is_shr ? ale : 1'b0;
            if (is_shr && ale_q && !ale)
                lat_addr <= dat_in;
        end
    end

    assign eff_addr = is_sep ? host_addr : lat_addr;
endmodule

// File: rtl/hrp_cycle_fsm.sv
module hrp_cycle_fsm
    import hrp_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ok,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              re_n,
    input  logic [7:0]        eff_addr,
    input  logic [WAIT_W-1:0] wait_len,
    output logic              wait_n,
    output logic              cm_wr,
    output logic              cm_rd,
    output logic [7:0]        cm_addr,
    output logic              rd_oe
);
    cyc_state_t        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic              kind_q, kind_d;
    logic [7:0]        addr_q, addr_d;
    logic              req, keep, commit, kind_now;

    assign req  = mode_ok && !cs_n && (!we_n || !re_n);
    assign keep = mode_ok && !cs_n && (kind_q ? !we_n : !re_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kind_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        kind_d  = kind_q;
        addr_d  = addr_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    kind_d = !we_n;
                    addr_d = eff_addr;
                    if (wait_len == '0) begin
                        state_d = ST_READY;
                        commit  = 1'b1;
                    end else begin
                        state_d = ST_STRETCH;
                        cnt_d   = wait_len - WAIT_W'(1);
                    end
                end
            end
            ST_STRETCH: begin
                if (!keep) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_READY;
                    commit  = 1'b1;
                end else begin
                    cnt_d = cnt_q - WAIT_W'(1);
                end
            end
            ST_READY: begin
                if (!keep) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        kind_now = (state_q == ST_IDLE) ? !we_n : kind_q;
        cm_addr  = (state_q == ST_IDLE) ? eff_addr : addr_q;
        cm_wr    = commit && kind_now;
        cm_rd    = commit && !kind_now;
        wait_n   = (state_q != ST_STRETCH);
        rd_oe    = (state_q == ST_READY) && !kind_q;
    end
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
    import hrp_pkg::*;
#(
    parameter int         WAIT_W   = 4,
    parameter int         WAIT_RST = 2,
    parameter int         NSCR     = 4,
    parameter logic [7:0] ID_VAL   = 8'hA7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cm_wr,
    input  logic              cm_rd,
    input  logic [7:0]        cm_addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        evt_in,
    output logic [7:0]        rdata,
    output logic [WAIT_W-1:0] wait_len,
    output logic              irq_n
);
    localparam int IW = (NSCR > 1) ? $clog2(NSCR) : 1;

    logic [7:0] status_q, enable_q, rd_mux;
    logic [7:0] scr_rd [NSCR];
    logic       scr_hit;
    logic [IW-1:0] scr_idx;
    logic       wr_status;

    assign scr_hit   = (cm_addr[7:IW] == A_SCR[7:IW]);
    assign scr_idx   = cm_addr[IW-1:0];
    assign wr_status = cm_wr && (cm_addr == A_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            wait_len <= WAIT_W'(WAIT_RST);
            rdata    <= '0;
        end else begin
            status_q <= (status_q & ~(wr_status ? wdata : 8'h00)) | evt_in;
            if (cm_wr && cm_addr == A_ENABLE) enable_q <= wdata;
            if (cm_wr && cm_addr == A_STRCH)  wait_len <= wdata[WAIT_W-1:0];
            if (cm_rd) rdata <= rd_mux;
        end
    end

    for (genvar g = 0; g < NSCR; g++) begin : g_scr
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (cm_wr && scr_hit && scr_idx == IW'(g))
                cell_q <= wdata;
        end
        assign scr_rd[g] = cell_q;
    end

    always_comb begin
        rd_mux = 8'h00;
        if (scr_hit)
            rd_mux = scr_rd[scr_idx];
        else if (cm_addr == A_STATUS)
            rd_mux = status_q;
        else if (cm_addr == A_ENABLE)
            rd_mux = enable_q;
        else if (cm_addr == A_STRCH)
            rd_mux = 8'(wait_len);
        else if (cm_addr == A_IDENT)
            rd_mux = ID_VAL;
    end

    assign irq_n = ~|(status_q & enable_q);
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hrp_pkg::*;
#(
    parameter int         WAIT_W   = 4,
    parameter int         WAIT_RST = 2,
    parameter int         NSCR     = 4,
    parameter logic [7:0] ID_VAL   = 8'hA7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic [7:0] host_addr,
    input  logic [7:0] dat_in,
    output logic [7:0] dat_out,
    output logic       dat_oe,
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       ale,
    output logic       wait_n,
    output logic       irq_n,
    input  logic [7:0] evt_in
);
    logic              mode_ok;
    logic [7:0]        eff_addr;
    logic [7:0]        lat_addr;
    logic              cm_wr, cm_rd;
    logic [7:0]        cm_addr;
    logic [WAIT_W-1:0] wait_len;

    hrp_addr_path u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .ale       (ale),
        .host_addr (host_addr),
        .dat_in    (dat_in),
        .mode_ok   (mode_ok),
        .eff_addr  (eff_addr),
        .lat_addr  (lat_addr)
    );

    hrp_cycle_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ok  (mode_ok),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .re_n     (re_n),
        .eff_addr (eff_addr),
        .wait_len (wait_len),
        .wait_n   (wait_n),
        .cm_wr    (cm_wr),
        .cm_rd    (cm_rd),
        .cm_addr  (cm_addr),
        .rd_oe    (dat_oe)
    );

    hrp_regfile #(
        .WAIT_W   (WAIT_W),
        .WAIT_RST (WAIT_RST),
        .NSCR     (NSCR),
        .ID_VAL   (ID_VAL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cm_wr    (cm_wr),
        .cm_rd    (cm_rd),
        .cm_addr  (cm_addr),
        .wdata    (dat_in),
        .evt_in   (evt_in),
        .rdata    (dat_out),
        .wait_len (wait_len),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
    parameter int WAIT_W = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       mode_ok,
    input logic [7:0] lat_addr,
    input logic       cs_n,
    input logic       re_n,
    input logic       wait_n,
    input logic       dat_oe,
    input logic       irq_n,
    input logic [7:0] evt_in,
    input logic       cm_wr
);
    localparam int MAXW = (1 << WAIT_W) - 1;

    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= 0;
        else
            low_run <= wait_n ? 0 : low_run + 1;
    end

    p_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (wait_n && !dat_oe));

    p_sep_ale_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b011) |=> $stable(lat_addr));

    p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> (low_run < MAXW));

    p_abort_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> $past(!cs_n && !re_n));

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(|evt_in) || $past(cm_wr)));
endmodule

bind hostreg_port hostreg_port_chk #(.WAIT_W(WAIT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .mode_ok  (mode_ok),
    .lat_addr (lat_addr),
    .cs_n     (cs_n),
    .re_n     (re_n),
    .wait_n   (wait_n),
    .dat_oe   (dat_oe),
    .irq_n    (irq_n),
    .evt_in   (evt_in),
    .cm_wr    (cm_wr)
);

// File: tb/hostreg_port_tb.sv
`timescale 1ns/1ps
module hostreg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b011;
    logic [7:0] host_addr = '0;
    logic [7:0] dat_in = '0;
    logic [7:0] dat_out;
    logic       dat_oe;
    logic       cs_n = 1'b1, we_n = 1'b1, re_n = 1'b1, ale = 1'b0;
    logic       wait_n, irq_n;
    logic [7:0] evt_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    hostreg_port u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_addr(host_addr),
        .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .cs_n(cs_n),
        .we_n(we_n), .re_n(re_n), .ale(ale), .wait_n(wait_n), .irq_n(irq_n),
        .evt_in(evt_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares read data when dat_oe first appears
    always @(negedge clk) begin
        if (dat_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected read", int'(dat_out), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(dat_out === e, t, int'(dat_out), int'(e));
            end
        end
        oe_prev = dat_oe;
    end

    // One host access, starting at a falling edge; d is write data or expected read data
    task automatic acc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input int exp_wait, input string tag);
        int n;
        host_addr = a;
        dat_in    = d;
        cs_n      = 1'b0;
        if (wr) we_n = 1'b0;
        else begin
            re_n = 1'b0;
            exp_q.push_back(d);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        n = 0;
        while (!wait_n && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_wait, {tag, " R4 wait length"}, n, exp_wait);
        cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ale_phase(input logic [7:0] a);
        dat_in = a;
        ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wait_n == 1'b1, "R11 wait_n after reset", wait_n, 1);
        chk(dat_oe == 1'b0, "R11 dat_oe after reset", dat_oe, 0);
        chk(irq_n == 1'b1, "R11 R10 irq_n after reset", irq_n, 1);

        // Separate mode, default stretch length 2
        acc(0, 8'h03, 8'hA7, 2, "R8 identity read");
        acc(0, 8'h02, 8'h02, 2, "R8 stretch reset value");
        acc(1, 8'h02, 8'h00, 2, "R5 set stretch 0");
        acc(1, 8'h10, 8'hA5, 0, "R5 scratch write");
        acc(1, 8'h13, 8'h3C, 0, "R5 scratch write top");
        acc(0, 8'h10, 8'hA5, 0, "R2 R8 scratch read low");
        acc(0, 8'h13, 8'h3C, 0, "R8 scratch read top");
        acc(1, 8'h40, 8'h77, 0, "R8 unmapped write");
        acc(0, 8'h40, 8'h00, 0, "R8 unmapped reads zero");
        acc(1, 8'h03, 8'h11, 0, "R8 identity write");
        acc(0, 8'h03, 8'hA7, 0, "R8 identity unchanged");

        // Longer stretch
        acc(1, 8'h02, 8'h03, 0, "R4 set stretch 3");
        acc(0, 8'h13, 8'h3C, 3, "R4 R6 stretched read");
        acc(1, 8'h11, 8'h5A, 3, "R5 stretched write");

        // Shared mode
        mode_sel = 3'b001;
        @(negedge clk);
        ale_phase(8'h12);
        acc(1, 8'hFF, 8'h69, 3, "R3 shared write");
        ale_phase(8'h11);
        acc(0, 8'h00, 8'h5A, 3, "R3 shared read");
        ale_phase(8'h12);
        acc(0, 8'h00, 8'h69, 3, "R3 shared read second");

        // Separate mode: ALE pulse must not move the shared address
        mode_sel = 3'b011;
        @(negedge clk);
        ale_phase(8'h10);
        mode_sel = 3'b001;
        @(negedge clk);
        acc(0, 8'h00, 8'h69, 3, "R2 ALE ignored in separate mode");

        // Inactive mode
        mode_sel = 3'b111;
        @(negedge clk);
        begin
            bit quiet;
            quiet = 1'b1;
            host_addr = 8'h10; dat_in = 8'hFF; cs_n = 1'b0; we_n = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (!wait_n || dat_oe) quiet = 1'b0;
            end
            chk(quiet, "R1 inactive mode quiet", quiet, 1);
            cs_n = 1'b1; we_n = 1'b1;
            @(negedge clk);
        end
        mode_sel = 3'b011;
        @(negedge clk);
        acc(0, 8'h10, 8'hA5, 3, "R1 no write in inactive mode");

        // Abort during stretch
        begin
            bit no_oe;
            no_oe = 1'b1;
            host_addr = 8'h10; dat_in = 8'h00; cs_n = 1'b0; we_n = 1'b0;
            @(negedge clk);
            chk(wait_n == 1'b0, "R4 wait low after start", wait_n, 0);
            cs_n = 1'b1; we_n = 1'b1;
            repeat (4) begin
                @(negedge clk);
                if (dat_oe || !wait_n) no_oe = 1'b0;
            end
            chk(no_oe, "R7 abort releases wait", no_oe, 1);
        end
        acc(0, 8'h10, 8'hA5, 3, "R7 aborted write not stored");

        // Interrupts
        acc(1, 8'h02, 8'h00, 3, "R4 set stretch 0 again");
        acc(1, 8'h01, 8'h05, 0, "R10 enable write");
        chk(irq_n == 1'b1, "R10 irq high with no status", irq_n, 1);
        evt_in = 8'h04;
        @(negedge clk);
        evt_in = 8'h00;
        chk(irq_n == 1'b0, "R9 R10 masked event raises irq", irq_n, 0);
        acc(0, 8'h00, 8'h04, 0, "R9 status after event");
        evt_in = 8'h02;
        @(negedge clk);
        evt_in = 8'h00;
        acc(0, 8'h00, 8'h06, 0, "R9 second event");
        acc(1, 8'h00, 8'h04, 0, "R10 clear enabled bit");
        chk(irq_n == 1'b1, "R10 irq released after clear", irq_n, 1);
        acc(0, 8'h00, 8'h02, 0, "R10 status after clear");

        // Set wins over clear at the same edge
        host_addr = 8'h00; dat_in = 8'h02; cs_n = 1'b0; we_n = 1'b0; evt_in = 8'h02;
        @(negedge clk);
        evt_in = 8'h00; cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        acc(0, 8'h00, 8'h02, 0, "R9 set wins over clear");
        chk(irq_n == 1'b1, "R10 unmasked bit keeps irq high", irq_n, 1);
        acc(1, 8'h01, 8'h02, 0, "R10 enable bit 1");
        chk(irq_n == 1'b0, "R10 enable write raises irq", irq_n, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads observed", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule